// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Controller

This block steers one warp whose 32 lanes share a single program counter. Each cycle the issue stage sees the current PC and the active-lane mask. It reports either a plain sequential advance or a conditional branch. A branch carries the per-lane outcome bits, the taken target, the fall-through address and the point where the two sides rejoin.

If every active lane agrees on the outcome, only the PC moves. If the lanes disagree, the two sides run one after the other. The taken side goes first with only its lanes enabled. Its companion is parked on an internal path stack, together with an entry that remembers the mask held before the branch. Reaching the rejoin address of the current path pops the stack, so the parked side runs next. After that side also reaches the rejoin point, the saved mask comes back. Nesting works through further pushes.

The controller never stalls: it takes one advance or branch per cycle. One copy is placed per warp, so a split in one warp has no effect on the others.

Top module: `simt_reconv_unit`

## Requirements
- R1: Under reset the PC is RESET_PC (default 0), the mask is all ones and the overflow flag is 0.
- R2: An advance without a branch adds 1 to the PC and keeps the mask. A cycle with neither input asserted keeps PC and mask.
- R3: A branch whose active lanes are all taken goes to the target, and one with no active lane taken goes to the fall-through. The mask is kept and the stack is untouched. Taken bits of inactive lanes are ignored.
- R4: On a split (active lanes disagree, and neither side starts at the rejoin address), the PC becomes the target and the mask becomes the taken active lanes. The mask never becomes zero.
- R5: When the PC of the running path reaches its rejoin address, the parked side starts next cycle at its fall-through address with the not-taken lanes.
- R6: When the second side reaches the rejoin address, the PC equals that address and the mask equals the mask held before the branch.
- R7: Nested splits are unwound innermost first, and each pop restores exactly the mask saved for its own level.
- R8: If the fall-through equals the rejoin address, only the taken side runs. If the target equals it, only the not-taken side runs. If both equal it, the branch acts as a uniform jump to that address.
- R9: A split whose rejoin address equals that of the enclosing path adds no level of its own. Its lanes rejoin through the enclosing level's entries.
- R10: A split needing more stack entries than are free (DEPTH, default 16) is ignored: PC, mask and stack stay unchanged. The overflow flag is set and holds until reset.
- R11: When branch and advance are both asserted, the branch is taken into effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A branch is issued this cycle |
| br_taken_i | input | 32 | Per-lane branch outcome, bit n for lane n |
| br_target_i | input | 32 | Taken-side address |
| br_fall_i | input | 32 | Not-taken-side address |
| br_reconv_i | input | 32 | Address where both sides rejoin |
| adv_valid_i | input | 1 | Sequential advance this cycle |
| pc_o | output | 32 | Current PC for the issue stage |
| mask_o | output | 32 | Current active-lane mask |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
The hardest state to reach from the ports is a full stack, which takes eight nested splits, each with its own rejoin address. The stimulus gets there by peeling off the lowest active lane at every level. It then issues a ninth split, and unwinds one level to show that the refused push left the stored entries intact. A table of vectors walks through uniform branches, two-level nesting and the single-sided and shared-rejoin forms. In those, each pop can only be told apart by the mask it restores.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;

  localparam int unsigned LANES = 32;
  localparam int unsigned PC_W  = 32;

  typedef logic [LANES-1:0] lane_mask_t;
  typedef logic [PC_W-1:0]  pc_t;

  // one path: where it runs, who runs it, where it ends
  typedef struct packed {
    pc_t        pc;
    lane_mask_t mask;
    pc_t        rpc;
  } path_t;

  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;

  function automatic lane_mask_t taken_lanes(lane_mask_t taken, lane_mask_t active);
    return taken & active;
  endfunction

  function automatic lane_mask_t fall_lanes(lane_mask_t taken, lane_mask_t active);
    return active & ~taken;
  endfunction

  function automatic logic lanes_disagree(lane_mask_t t_act, lane_mask_t active);
    return (t_act != '0) && (t_act != active);
  endfunction

  function automatic pc_t seq_pc(pc_t pc);
    return pc + pc_t'(1);
  endfunction

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_reconv_pkg::*;
(
  input  path_t      cur_i,
  input  logic       depth_nz_i,
  input  logic       br_valid_i,
  input  lane_mask_t br_taken_i,
  input  pc_t        br_target_i,
  input  pc_t        br_fall_i,
  input  pc_t        br_reconv_i,
  input  logic       adv_valid_i,
  output path_t      nxt_o,
  output push_e      push_cnt_o,
  output path_t      push_a_o,
  output path_t      push_b_o,
  output logic       split_o
);

  lane_mask_t t_act;
  lane_mask_t f_act;
  logic       need_rejoin;
  logic       tgt_empty;
  logic       fall_empty;
  path_t      rejoin_ent;
  path_t      fall_ent;
  path_t      taken_path;

  assign t_act       = taken_lanes(br_taken_i, cur_i.mask);
  assign f_act       = fall_lanes(br_taken_i, cur_i.mask);
  assign tgt_empty   = (br_target_i == br_reconv_i);
  assign fall_empty  = (br_fall_i == br_reconv_i);
  // a rejoin shared with the enclosing level is covered by that level
  assign need_rejoin = !(depth_nz_i && (br_reconv_i == cur_i.rpc));
  assign rejoin_ent  = path_t'{pc: br_reconv_i, mask: cur_i.mask, rpc: cur_i.rpc};
  assign fall_ent    = path_t'{pc: br_fall_i, mask: f_act, rpc: br_reconv_i};
  assign taken_path  = path_t'{pc: br_target_i, mask: t_act, rpc: br_reconv_i};

  always_comb begin
    nxt_o      = cur_i;
    push_cnt_o = PUSH_NONE;
    push_a_o   = '0;
    push_b_o   = '0;
    split_o    = 1'b0;
    if (br_valid_i) begin
      if (!lanes_disagree(t_act, cur_i.mask) || (tgt_empty && fall_empty)) begin
        if (t_act == '0)             nxt_o.pc = br_fall_i;
        else if (t_act == cur_i.mask) nxt_o.pc = br_target_i;
        else                          nxt_o.pc = br_reconv_i;
      end else begin
        split_o = 1'b1;
        if (tgt_empty || fall_empty) begin
          nxt_o = tgt_empty ? fall_ent : taken_path;
          if (need_rejoin) begin
            push_cnt_o = PUSH_ONE;
            push_a_o   = rejoin_ent;
          end
        end else begin
          nxt_o = taken_path;
          if (need_rejoin) begin
            push_cnt_o = PUSH_TWO;
            push_a_o   = rejoin_ent;
            push_b_o   = fall_ent;
          end else begin
            push_cnt_o = PUSH_ONE;
            push_a_o   = fall_ent;
          end
        end
      end
    end else if (adv_valid_i) begin
      nxt_o.pc = seq_pc(cur_i.pc);
    end
  end

endmodule

// File: rtl/simt_path_stack.sv
module simt_path_stack
  import simt_reconv_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  push_e push_cnt_i,
  input  path_t push_a_i,
  input  path_t push_b_i,
  input  logic  pop_i,
  output path_t top_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] depth_p1;
  path_t            slots [DEPTH];

  assign depth_p1 = depth_q + CNT_W'(1);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    path_t slot_q;
    logic  wr_a;
    logic  wr_b;
    assign wr_a = (push_cnt_i != PUSH_NONE) && (depth_q == CNT_W'(s));
    assign wr_b = (push_cnt_i == PUSH_TWO) && (depth_p1 == CNT_W'(s));
    always_ff @(posedge clk) begin
      if (wr_a)      slot_q <= push_a_i;
      else if (wr_b) slot_q <= push_b_i;
    end
    assign slots[s] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        depth_q <= '0;
    else if (pop_i)                    depth_q <= depth_q - CNT_W'(1);
    else if (push_cnt_i != PUSH_NONE)  depth_q <= depth_q + CNT_W'(push_cnt_i);
  end

  assign top_o   = (depth_q != '0) ? slots[IDX_W'(depth_q - CNT_W'(1))] : '0;
  assign depth_o = depth_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_cnt_i != PUSH_NONE) |-> (int'(depth_q) + int'(push_cnt_i) <= int'(DEPTH)));

  // R7
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && (push_cnt_i != PUSH_NONE)));

  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (depth_q != '0));

endmodule

// File: rtl/simt_reconv_unit.sv
module simt_reconv_unit
  import simt_reconv_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter pc_t         RESET_PC = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   br_valid_i,
  input  logic [LANES-1:0]       br_taken_i,
  input  logic [PC_W-1:0]        br_target_i,
  input  logic [PC_W-1:0]        br_fall_i,
  input  logic [PC_W-1:0]        br_reconv_i,
  input  logic                   adv_valid_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [LANES-1:0]       mask_o,
  output logic                   overflow_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  path_t            cur_q;
  path_t            nxt;
  path_t            commit;
  path_t            push_a;
  path_t            push_b;
  path_t            top_ent;
  push_e            push_cnt;
  push_e            push_eff;
  logic             split;
  logic             split_go;
  logic             ovf_evt;
  logic             pop_go;
  logic             ovf_q;
  logic [CNT_W-1:0] depth;

  simt_branch_eval u_eval (
    .cur_i       (cur_q),
    .depth_nz_i  (depth != '0),
    .br_valid_i  (br_valid_i),
    .br_taken_i  (br_taken_i),
    .br_target_i (br_target_i),
    .br_fall_i   (br_fall_i),
    .br_reconv_i (br_reconv_i),
    .adv_valid_i (adv_valid_i),
    .nxt_o       (nxt),
    .push_cnt_o  (push_cnt),
    .push_a_o    (push_a),
    .push_b_o    (push_b),
    .split_o     (split)
  );

  // a split that does not fit is refused whole
  assign ovf_evt  = (push_cnt != PUSH_NONE) &&
                    (int'(depth) + int'(push_cnt) > int'(DEPTH));
  assign commit   = ovf_evt ? cur_q : nxt;
  assign push_eff = ovf_evt ? PUSH_NONE : push_cnt;
  assign split_go = split && !ovf_evt;
  assign pop_go   = (push_eff == PUSH_NONE) && (depth != '0) && (commit.pc == commit.rpc);

  simt_path_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_cnt_i (push_eff),
    .push_a_i   (push_a),
    .push_b_i   (push_b),
    .pop_i      (pop_go),
    .top_o      (top_ent),
    .depth_o    (depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= path_t'{pc: RESET_PC, mask: '1, rpc: '0};
      ovf_q <= 1'b0;
    end else begin
      cur_q <= pop_go ? top_ent : commit;
      ovf_q <= ovf_q | ovf_evt;
    end
  end

  assign pc_o       = cur_q.pc;
  assign mask_o     = cur_q.mask;
  assign overflow_o = ovf_q;

  // R4
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o != '0);

  // R4
  split_narrows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |=> (((cur_q.mask & ~$past(cur_q.mask)) == '0) &&
                  (cur_q.mask != $past(cur_q.mask))));

  // R5
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> (cur_q == $past(top_ent)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cur_q == $past(cur_q)));

endmodule

// File: tb/sim_simt_reconv_unit.sv
`timescale 1ns/1ps
module sim_simt_reconv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_taken = '0;
  logic [31:0] br_target = '0;
  logic [31:0] br_fall = '0;
  logic [31:0] br_reconv = '0;
  logic        adv_valid = 1'b0;
  logic [31:0] pc;
  logic [31:0] mask;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;
  logic [31:0] m;
  logic [31:0] nm;

  always #5 clk = ~clk;

  simt_reconv_unit u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid_i  (br_valid),
    .br_taken_i  (br_taken),
    .br_target_i (br_target),
    .br_fall_i   (br_fall),
    .br_reconv_i (br_reconv),
    .adv_valid_i (adv_valid),
    .pc_o        (pc),
    .mask_o      (mask),
    .overflow_o  (ovf)
  );

  typedef struct packed {
    logic        br;
    logic        adv;
    logic [31:0] tk;
    logic [31:0] tg;
    logic [31:0] ft;
    logic [31:0] rc;
    logic [31:0] epc;
    logic [31:0] emk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 32'h0,        32'd0,   32'd0,   32'd0,   32'd1,   32'hFFFFFFFF, 8'd2},  // R2 advance
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd10,  32'd11,  32'd12,  32'd10,  32'hFFFFFFFF, 8'd3},  // R3 all taken
    '{1'b1, 1'b0, 32'h0,        32'd99,  32'd11,  32'd12,  32'd11,  32'hFFFFFFFF, 8'd3},  // R3 none taken
    '{1'b0, 1'b0, 32'h0,        32'd0,   32'd0,   32'd0,   32'd11,  32'hFFFFFFFF, 8'd2},  // R2 idle holds
    '{1'b1, 1'b0, 32'h0000FFFF, 32'd20,  32'd30,  32'd40,  32'd20,  32'h0000FFFF, 8'd4},  // R4 split
    '{1'b0, 1'b1, 32'h0,        32'd0,   32'd0,   32'd0,   32'd21,  32'h0000FFFF, 8'd2},
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd40,  32'd22,  32'd45,  32'd30,  32'hFFFF0000, 8'd5},  // R5 parked side
    '{1'b0, 1'b1, 32'h0,        32'd0,   32'd0,   32'd0,   32'd31,  32'hFFFF0000, 8'd2},
    '{1'b1, 1'b0, 32'h0,        32'd77,  32'd40,  32'd41,  32'd40,  32'hFFFFFFFF, 8'd6},  // R6 rejoin
    '{1'b1, 1'b0, 32'h00FF00FF, 32'd50,  32'd60,  32'd90,  32'd50,  32'h00FF00FF, 8'd4},
    '{1'b1, 1'b0, 32'h000000FF, 32'd70,  32'd80,  32'd85,  32'd70,  32'h000000FF, 8'd7},  // R7 inner split
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd85,  32'd71,  32'd99,  32'd80,  32'h00FF0000, 8'd7},  // R7, R3 inactive bits
    '{1'b1, 1'b0, 32'h0,        32'd1,   32'd85,  32'd2,   32'd85,  32'h00FF00FF, 8'd7},  // R7 inner rejoin
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd90,  32'd3,   32'd4,   32'd60,  32'hFF00FF00, 8'd7},
    '{1'b1, 1'b0, 32'h0,        32'd5,   32'd90,  32'd6,   32'd90,  32'hFFFFFFFF, 8'd6},
    '{1'b1, 1'b0, 32'h0F0F0F0F, 32'd100, 32'd110, 32'd110, 32'd100, 32'h0F0F0F0F, 8'd8},  // R8 no else
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd110, 32'd7,   32'd8,   32'd110, 32'hFFFFFFFF, 8'd8},
    '{1'b1, 1'b0, 32'hF0F0F0F0, 32'd120, 32'd121, 32'd120, 32'd121, 32'h0F0F0F0F, 8'd8},  // R8 empty taken
    '{1'b1, 1'b0, 32'h0,        32'd9,   32'd120, 32'd9,   32'd120, 32'hFFFFFFFF, 8'd8},
    '{1'b1, 1'b0, 32'h0000FFFF, 32'd130, 32'd140, 32'd150, 32'd130, 32'h0000FFFF, 8'd9},  // R9 outer
    '{1'b1, 1'b0, 32'h000000FF, 32'd131, 32'd135, 32'd150, 32'd131, 32'h000000FF, 8'd9},  // R9 shared rejoin
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd150, 32'd1,   32'd2,   32'd135, 32'h0000FF00, 8'd9},
    '{1'b1, 1'b0, 32'hFFFFFFFF, 32'd150, 32'd1,   32'd2,   32'd140, 32'hFFFF0000, 8'd9},
    '{1'b1, 1'b0, 32'h0,        32'd3,   32'd150, 32'd4,   32'd150, 32'hFFFFFFFF, 8'd9},
    '{1'b1, 1'b0, 32'h00000001, 32'd160, 32'd160, 32'd160, 32'd160, 32'hFFFFFFFF, 8'd8},  // R8 both empty
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'd170, 32'd5,   32'd6,   32'd170, 32'hFFFFFFFF, 8'd11}, // R11 priority
    '{1'b0, 1'b1, 32'h0,        32'd0,   32'd0,   32'd0,   32'd171, 32'hFFFFFFFF, 8'd2}
  };

  task automatic drive(input logic b, input logic a, input logic [31:0] tk, tg, ft, rc);
    @(negedge clk);
    br_valid = b; adv_valid = a; br_taken = tk;
    br_target = tg; br_fall = ft; br_reconv = rc;
    @(posedge clk);
    #2;
    br_valid = 1'b0; adv_valid = 1'b0;
  endtask

  task automatic check(input int req, input logic [31:0] epc, emk, input logic eovf);
    checks++;
    if (pc !== epc || mask !== emk || ovf !== eovf) begin
      fails++;
      $display("FAIL R%0d: pc=%0d mask=%h ovf=%b expected pc=%0d mask=%h ovf=%b",
               req, pc, mask, ovf, epc, emk, eovf);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(1, 32'd0, 32'hFFFFFFFF, 1'b0);           // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(1, 32'd0, 32'hFFFFFFFF, 1'b0);           // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].br, VEC[i].adv, VEC[i].tk, VEC[i].tg, VEC[i].ft, VEC[i].rc);
      check(int'(VEC[i].req), VEC[i].epc, VEC[i].emk, 1'b0);
    end

    // R4 fill the stack: peel the lowest active lane per level
    m = 32'hFFFFFFFF;
    for (int i = 0; i < 8; i++) begin
      nm = m & ~(m & (~m + 32'd1));
      drive(1'b1, 1'b0, nm, 32'd200 + i, 32'd300 + i, 32'd1000 + i);
      check(4, 32'd200 + i, nm, 1'b0);
      m = nm;
    end
    // R10 ninth split does not fit
    drive(1'b1, 1'b0, 32'hFFFFFE00, 32'd208, 32'd308, 32'd1008);
    check(10, 32'd207, 32'hFFFFFF00, 1'b1);
    drive(1'b0, 1'b0, 32'h0, 32'd0, 32'd0, 32'd0);
    check(10, 32'd207, 32'hFFFFFF00, 1'b1);        // R10 flag sticky
    drive(1'b1, 1'b0, 32'hFFFFFFFF, 32'd1007, 32'd1, 32'd2);
    check(10, 32'd307, 32'h00000080, 1'b1);        // R10 stack intact

    @(negedge clk); rst_n = 1'b0;
    #2;
    check(1, 32'd0, 32'hFFFFFFFF, 1'b0);           // R1 reset clears flag
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(1, 32'd0, 32'hFFFFFFFF, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule